// File: doc/BRIEF.md
# Two-Wide In-Order Dispatch with Rename Tagging

This block sits between the instruction queue and the reservation stations. Each cycle it looks at the two oldest decoded instructions. An instruction dispatches only when three resources are free at the same time: a reservation station at its target unit, a rename buffer for its destination, and a slot in the completion queue. Dispatch is in order, so the younger candidate can never go out ahead of the older one. Each dispatched instruction that writes an architected register gets a rename buffer. Its source operands are looked up in a register-to-buffer map. A source whose value is still being produced leaves the block as a buffer tag and a pending flag, not as a value.

The block owns the rename state: a free mask of buffers, a pending flag per buffer, and a valid bit plus tag per architected register. A result broadcast clears a buffer's pending flag. A broadcast in the same cycle is forwarded, so the source already reads as ready. Two retirement ports return buffers to the free mask. A register whose latest mapping is retired falls back to the architected file. The dispatch outputs are combinational, and the reservation stations latch them at the next clock edge.

Top module: `disp_stage`

## Requirements
- R1: After reset all eight rename buffers are free, no mapping is valid and nothing dispatches while no candidate is valid. The first two allocations after reset return tags 0 and 1.
- R2: The older candidate (slot 0) dispatches exactly when all of these hold: it is valid; the unit field ANDed with `rs_free` is non-zero (bit i of the one-hot unit field selects unit i); `cq_free` is at least 1; and, if it has a destination, at least one buffer is free.
- R3: The younger candidate (slot 1) dispatches only if the older one does in the same cycle. It also needs `cq_free` of at least 2, a free station at a unit the older instruction does not take in that cycle, and enough free buffers for both destinations.
- R4: A dispatched older destination takes the lowest-index free buffer. A dispatched younger destination takes the next free one above it, or the lowest if the older has no destination. A buffer stays allocated until it is retired. `disp_dst_tag` is 0 for a slot that is not dispatched or has no destination.
- R5: A dispatched source is reported pending, with the tag of the buffer that will supply it, when its register's latest mapping is a buffer whose result has not yet been broadcast. All source outputs of a slot that is not dispatched are 0.
- R6: When both slots dispatch, a younger source that names the older instruction's destination register is reported pending with the older instruction's newly allocated tag.
- R7: A broadcast clears the buffer's pending flag from the next cycle on. A broadcast in the same cycle already makes a matching source read as not pending.
- R8: A retired buffer can be allocated again from the next cycle. A register whose latest mapping was that buffer then reads as not pending.
- R9: A source whose register has no valid mapping is reported not pending with tag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cand_vld | input | 2 | Candidate valid; bit 0 is the older instruction |
| cand_unit | input | 2x4 | One-hot target unit per candidate |
| cand_dst_en | input | 2 | Candidate writes an architected register |
| cand_dst | input | 2x4 | Destination architected register |
| cand_src | input | 2x2x4 | Two source registers per candidate |
| rs_free | input | 4 | Per-unit reservation station has a free entry |
| cq_free | input | 2 | Free completion-queue slots (saturating 0..3) |
| bc_vld | input | 1 | Result broadcast valid |
| bc_tag | input | 3 | Broadcast buffer tag |
| ret_vld | input | 2 | Retirement port valid |
| ret_tag | input | 2x3 | Buffer retired on each port |
| disp_vld | output | 2 | Slot dispatched this cycle (removed from queue) |
| disp_dst_tag | output | 2x3 | Allocated destination buffer |
| disp_src_pend | output | 2x2 | Source is waiting on a buffer |
| disp_src_tag | output | 2x2x3 | Producer buffer tag for a pending source |

## Verification
Assertions check these on every cycle: in-order issue, the completion-slot and station conditions for each slot, that the two slots never claim the same unit, and that an allocated tag was free and is taken from the next cycle on. They also check that a pending source never carries the tag being broadcast in the same cycle. Some behaviour depends on history across cycles, and only the bench's scenarios can show it: lowest-first allocation order, correct tags after remapping, pending flags cleared by earlier broadcasts, freed buffers being reused, and the mapping falling back after retirement. The bench checks these against its own model of the rename state under random and directed traffic.

// File: rtl/disp_pkg.sv
package disp_pkg;
    localparam int NUM_REN  = 8;
    localparam int TAG_W    = $clog2(NUM_REN);
    localparam int CNT_W    = TAG_W + 1;
    localparam int NUM_AREG = 16;
    localparam int AREG_W   = $clog2(NUM_AREG);
    localparam int NUM_UNIT = 4;
    localparam int CQ_W     = 2;
    localparam int NUM_SLOT = 2;
    localparam int NUM_SRC  = 2;
    localparam int NUM_RET  = 2;

    typedef struct packed {
        logic [NUM_REN-1:0]             free;
        logic [NUM_REN-1:0]             pend;
        logic [NUM_AREG-1:0]            map_v;
        logic [NUM_AREG-1:0][TAG_W-1:0] map_t;
    } ren_state_t;
endpackage

// File: rtl/disp_pick.sv
module disp_pick #(
    parameter int N  = 8,
    parameter int TW = 3,
    parameter int CW = 4
) (
    input  logic [N-1:0]  free_mask,
    output logic [TW-1:0] first_tag,
    output logic [TW-1:0] second_tag,
    output logic [CW-1:0] free_cnt
);
    logic seen_a;
    logic seen_b;

    always_comb begin
        first_tag  = '0;
        second_tag = '0;
        free_cnt   = '0;
        seen_a     = 1'b0;
        seen_b     = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (free_mask[i]) begin
                free_cnt = free_cnt + CW'(1);
                if (!seen_a) begin
                    first_tag = TW'(i);
                    seen_a    = 1'b1;
                end else if (!seen_b) begin
                    second_tag = TW'(i);
                    seen_b     = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/disp_qual.sv
module disp_qual #(
    parameter int NU = 4,
    parameter int QW = 2,
    parameter int CW = 4
) (
    input  logic [1:0]         vld,
    input  logic [1:0][NU-1:0] unit,
    input  logic [1:0]         dst_en,
    input  logic [NU-1:0]      rs_free,
    input  logic [QW-1:0]      cq_free,
    input  logic [CW-1:0]      free_cnt,
    output logic [1:0]         go
);
    logic [NU-1:0] left_rs;
    logic [CW-1:0] need_old;
    logic [CW-1:0] need_both;

    always_comb begin
        need_old  = CW'(dst_en[0]);
        go[0]     = vld[0] && (|(unit[0] & rs_free)) &&
                    (cq_free >= QW'(1)) && (free_cnt >= need_old);
        left_rs   = rs_free & ~(go[0] ? unit[0] : '0);
        need_both = CW'(go[0] && dst_en[0]) + CW'(dst_en[1]);
        go[1]     = go[0] && vld[1] && (|(unit[1] & left_rs)) &&
                    (cq_free >= QW'(2)) && (free_cnt >= need_both);
    end
endmodule

// File: rtl/disp_lookup.sv
module disp_lookup #(
    parameter int NA = 16,
    parameter int AW = 4,
    parameter int NR = 8,
    parameter int TW = 3
) (
    input  logic [AW-1:0]         areg,
    input  logic [NA-1:0]         map_v,
    input  logic [NA-1:0][TW-1:0] map_t,
    input  logic [NR-1:0]         pend,
    input  logic                  bc_vld,
    input  logic [TW-1:0]         bc_tag,
    input  logic                  fwd_hit,
    input  logic [TW-1:0]         fwd_tag,
    output logic                  src_pend,
    output logic [TW-1:0]         src_tag
);
    logic [TW-1:0] mapped;
    logic          waiting;

    always_comb begin
        mapped  = map_t[areg];
        waiting = map_v[areg] && pend[mapped] && !(bc_vld && (bc_tag == mapped));
        if (fwd_hit) begin
            src_pend = 1'b1;
            src_tag  = fwd_tag;
        end else begin
            src_pend = waiting;
            src_tag  = waiting ? mapped : '0;
        end
    end
endmodule

// File: rtl/disp_stage.sv
module disp_stage
    import disp_pkg::*;
(
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic [NUM_SLOT-1:0]                       cand_vld,
    input  logic [NUM_SLOT-1:0][NUM_UNIT-1:0]         cand_unit,
    input  logic [NUM_SLOT-1:0]                       cand_dst_en,
    input  logic [NUM_SLOT-1:0][AREG_W-1:0]           cand_dst,
    input  logic [NUM_SLOT-1:0][NUM_SRC-1:0][AREG_W-1:0] cand_src,
    input  logic [NUM_UNIT-1:0]                       rs_free,
    input  logic [CQ_W-1:0]                           cq_free,
    input  logic                                      bc_vld,
    input  logic [TAG_W-1:0]                          bc_tag,
    input  logic [NUM_RET-1:0]                        ret_vld,
    input  logic [NUM_RET-1:0][TAG_W-1:0]             ret_tag,
    output logic [NUM_SLOT-1:0]                       disp_vld,
    output logic [NUM_SLOT-1:0][TAG_W-1:0]            disp_dst_tag,
    output logic [NUM_SLOT-1:0][NUM_SRC-1:0]          disp_src_pend,
    output logic [NUM_SLOT-1:0][NUM_SRC-1:0][TAG_W-1:0] disp_src_tag
);
    ren_state_t st_d, st_q;

    logic [NUM_REN-1:0] free_q;
    logic [TAG_W-1:0]   pick_a, pick_b;
    logic [CNT_W-1:0]   free_cnt;
    logic [1:0]         go;
    logic [NUM_SLOT-1:0][TAG_W-1:0] new_tag;
    logic [NUM_SLOT-1:0][NUM_SRC-1:0] lk_pend;
    logic [NUM_SLOT-1:0][NUM_SRC-1:0][TAG_W-1:0] lk_tag;

    assign free_q = st_q.free;

    disp_pick #(.N(NUM_REN), .TW(TAG_W), .CW(CNT_W)) u_pick (
        .free_mask (st_q.free),
        .first_tag (pick_a),
        .second_tag(pick_b),
        .free_cnt  (free_cnt)
    );

    disp_qual #(.NU(NUM_UNIT), .QW(CQ_W), .CW(CNT_W)) u_qual (
        .vld     (cand_vld),
        .unit    (cand_unit),
        .dst_en  (cand_dst_en),
        .rs_free (rs_free),
        .cq_free (cq_free),
        .free_cnt(free_cnt),
        .go      (go)
    );

    assign new_tag[0] = pick_a;
    assign new_tag[1] = (go[0] && cand_dst_en[0]) ? pick_b : pick_a;

    for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
        for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
            logic fwd_hit;
            if (s == 0) begin : g_old
                assign fwd_hit = 1'b0;
            end else begin : g_young
                assign fwd_hit = go[0] && cand_dst_en[0] &&
                                 (cand_dst[0] == cand_src[s][k]);
            end
            disp_lookup #(.NA(NUM_AREG), .AW(AREG_W), .NR(NUM_REN), .TW(TAG_W)) u_lk (
                .areg    (cand_src[s][k]),
                .map_v   (st_q.map_v),
                .map_t   (st_q.map_t),
                .pend    (st_q.pend),
                .bc_vld  (bc_vld),
                .bc_tag  (bc_tag),
                .fwd_hit (fwd_hit),
                .fwd_tag (new_tag[0]),
                .src_pend(lk_pend[s][k]),
                .src_tag (lk_tag[s][k])
            );
            assign disp_src_pend[s][k] = go[s] && lk_pend[s][k];
            assign disp_src_tag[s][k]  = go[s] ? lk_tag[s][k] : '0;
        end
        assign disp_vld[s]     = go[s];
        assign disp_dst_tag[s] = (go[s] && cand_dst_en[s]) ? new_tag[s] : '0;
    end

    always_comb begin
        st_d = st_q;
        for (int p = 0; p < NUM_RET; p++) begin
            if (ret_vld[p]) begin
                st_d.free[ret_tag[p]] = 1'b1;
                st_d.pend[ret_tag[p]] = 1'b0;
                for (int a = 0; a < NUM_AREG; a++) begin
                    if (st_q.map_v[a] && (st_q.map_t[a] == ret_tag[p])) begin
                        st_d.map_v[a] = 1'b0;
                    end
                end
            end
        end
        if (bc_vld) begin
            st_d.pend[bc_tag] = 1'b0;
        end
        for (int s = 0; s < NUM_SLOT; s++) begin
            if (go[s] && cand_dst_en[s]) begin
                st_d.free[new_tag[s]]    = 1'b0;
                st_d.pend[new_tag[s]]    = 1'b1;
                st_d.map_v[cand_dst[s]]  = 1'b1;
                st_d.map_t[cand_dst[s]]  = new_tag[s];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.free  <= '1;
            st_q.pend  <= '0;
            st_q.map_v <= '0;
            st_q.map_t <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/disp_stage_chk.sv
module disp_stage_chk
    import disp_pkg::*;
(
    input logic                                       clk,
    input logic                                       rst_n,
    input logic [NUM_SLOT-1:0]                        cand_vld,
    input logic [NUM_SLOT-1:0][NUM_UNIT-1:0]          cand_unit,
    input logic [NUM_SLOT-1:0]                        cand_dst_en,
    input logic [NUM_UNIT-1:0]                        rs_free,
    input logic [CQ_W-1:0]                            cq_free,
    input logic                                       bc_vld,
    input logic [TAG_W-1:0]                           bc_tag,
    input logic [NUM_SLOT-1:0]                        disp_vld,
    input logic [NUM_SLOT-1:0][TAG_W-1:0]             disp_dst_tag,
    input logic [NUM_SLOT-1:0][NUM_SRC-1:0]           disp_src_pend,
    input logic [NUM_SLOT-1:0][NUM_SRC-1:0][TAG_W-1:0] disp_src_tag,
    input logic [NUM_REN-1:0]                         free_q
);
    // R3
    in_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_vld[1] |-> disp_vld[0]);
    // R2
    old_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_vld[0] |-> cand_vld[0]);
    // R2
    old_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_vld[0] |-> (cq_free != '0) && (|(cand_unit[0] & rs_free)));
    // R3
    young_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_vld[1] |-> (cq_free >= CQ_W'(2)) && cand_vld[1]);
    // R3
    unit_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&disp_vld) |-> (|(cand_unit[1] & rs_free & ~cand_unit[0])));
    // R4
    alloc_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_vld[0] && cand_dst_en[0]) |-> free_q[disp_dst_tag[0]]);
    // R4
    alloc_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_vld[0] && cand_dst_en[0]) |=> !free_q[$past(disp_dst_tag[0])]);
    // R4
    distinct_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((&disp_vld) && (&cand_dst_en)) |-> (disp_dst_tag[0] != disp_dst_tag[1]));
    // R7
    bc_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_src_pend[0][0] && bc_vld) |-> (disp_src_tag[0][0] != bc_tag));
    // R7
    bc_fwd_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_src_pend[0][1] && bc_vld) |-> (disp_src_tag[0][1] != bc_tag));
    // R5
    idle_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_vld[1] |-> (disp_src_pend[1] == '0));
endmodule

bind disp_stage disp_stage_chk u_chk (
    .clk, .rst_n, .cand_vld, .cand_unit, .cand_dst_en, .rs_free, .cq_free,
    .bc_vld, .bc_tag, .disp_vld, .disp_dst_tag, .disp_src_pend, .disp_src_tag,
    .free_q
);

// File: tb/tb_disp_stage.sv
module tb_disp_stage;
    import disp_pkg::*;

    logic clk = 1'b0;
    logic rst_n;
    logic [1:0]            cand_vld;
    logic [1:0][3:0]       cand_unit;
    logic [1:0]            cand_dst_en;
    logic [1:0][3:0]       cand_dst;
    logic [1:0][1:0][3:0]  cand_src;
    logic [3:0]            rs_free;
    logic [1:0]            cq_free;
    logic                  bc_vld;
    logic [2:0]            bc_tag;
    logic [1:0]            ret_vld;
    logic [1:0][2:0]       ret_tag;
    logic [1:0]            disp_vld;
    logic [1:0][2:0]       disp_dst_tag;
    logic [1:0][1:0]       disp_src_pend;
    logic [1:0][1:0][2:0]  disp_src_tag;

    disp_stage dut (
        .clk(clk), .rst_n(rst_n), .cand_vld(cand_vld), .cand_unit(cand_unit),
        .cand_dst_en(cand_dst_en), .cand_dst(cand_dst), .cand_src(cand_src),
        .rs_free(rs_free), .cq_free(cq_free), .bc_vld(bc_vld), .bc_tag(bc_tag),
        .ret_vld(ret_vld), .ret_tag(ret_tag), .disp_vld(disp_vld),
        .disp_dst_tag(disp_dst_tag), .disp_src_pend(disp_src_pend),
        .disp_src_tag(disp_src_tag)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0]        m_free, m_pend;
    logic [15:0]       m_mapv;
    logic [15:0][2:0]  m_mapt;

    logic [1:0]           e_go;
    logic [1:0][2:0]      e_tag;
    logic [1:0][1:0]      e_pend;
    logic [1:0][1:0][2:0] e_stag;

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic calc();
        int cnt = 0;
        int fa = -1;
        int fb = -1;
        logic [3:0] left;
        int need1;
        logic [2:0] t0, t1;
        for (int i = 0; i < 8; i++) begin
            if (m_free[i]) begin
                cnt++;
                if (fa < 0) fa = i;
                else if (fb < 0) fb = i;
            end
        end
        if (fa < 0) fa = 0;
        if (fb < 0) fb = 0;
        e_go[0] = cand_vld[0] && (|(cand_unit[0] & rs_free)) && (cq_free >= 1)
                  && (cnt >= int'(cand_dst_en[0]));
        left  = rs_free & ~(e_go[0] ? cand_unit[0] : 4'h0);
        need1 = int'(e_go[0] && cand_dst_en[0]) + int'(cand_dst_en[1]);
        e_go[1] = e_go[0] && cand_vld[1] && (|(cand_unit[1] & left)) &&
                  (cq_free >= 2) && (cnt >= need1);
        t0 = 3'(fa);
        t1 = (e_go[0] && cand_dst_en[0]) ? 3'(fb) : 3'(fa);
        e_tag[0] = (e_go[0] && cand_dst_en[0]) ? t0 : 3'd0;
        e_tag[1] = (e_go[1] && cand_dst_en[1]) ? t1 : 3'd0;
        for (int s = 0; s < 2; s++) begin
            for (int k = 0; k < 2; k++) begin
                logic [3:0] r;
                logic [2:0] mt;
                logic p;
                r  = cand_src[s][k];
                mt = m_mapt[r];
                p  = m_mapv[r] && m_pend[mt] && !(bc_vld && bc_tag == mt);
                if (s == 1 && e_go[0] && cand_dst_en[0] && cand_dst[0] == r) begin
                    p  = 1'b1;
                    mt = t0;
                end
                e_pend[s][k] = e_go[s] && p;
                e_stag[s][k] = (e_go[s] && p) ? mt : 3'd0;
            end
        end
    endtask

    task automatic apply();
        for (int p = 0; p < 2; p++) begin
            if (ret_vld[p]) begin
                for (int a = 0; a < 16; a++)
                    if (m_mapv[a] && m_mapt[a] == ret_tag[p]) m_mapv[a] = 1'b0;
                m_free[ret_tag[p]] = 1'b1;
                m_pend[ret_tag[p]] = 1'b0;
            end
        end
        if (bc_vld) m_pend[bc_tag] = 1'b0;
        for (int s = 0; s < 2; s++) begin
            if (e_go[s] && cand_dst_en[s]) begin
                m_free[e_tag[s]]      = 1'b0;
                m_pend[e_tag[s]]      = 1'b1;
                m_mapv[cand_dst[s]]   = 1'b1;
                m_mapt[cand_dst[s]]   = e_tag[s];
            end
        end
    endtask

    task automatic step();
        #1;
        calc();
        check("R2", "disp_vld[0]", int'(disp_vld[0]), int'(e_go[0]));
        check("R3", "disp_vld[1]", int'(disp_vld[1]), int'(e_go[1]));
        for (int s = 0; s < 2; s++) begin
            check("R4", "disp_dst_tag", int'(disp_dst_tag[s]), int'(e_tag[s]));
            for (int k = 0; k < 2; k++) begin
                check("R5", "src_pend", int'(disp_src_pend[s][k]), int'(e_pend[s][k]));
                check("R5", "src_tag", int'(disp_src_tag[s][k]), int'(e_stag[s][k]));
            end
        end
    endtask

    task automatic adv();
        @(posedge clk);
        apply();
        @(negedge clk);
    endtask

    task automatic idle();
        cand_vld = 2'b00; cand_unit = '0; cand_dst_en = 2'b00; cand_dst = '0;
        cand_src = '0; rs_free = 4'hF; cq_free = 2'd3; bc_vld = 1'b0;
        bc_tag = '0; ret_vld = 2'b00; ret_tag = '0;
    endtask

    task automatic set_c(int s, int unit, bit de, int dst, int a, int b);
        cand_vld[s]    = 1'b1;
        cand_unit[s]   = 4'(unit);
        cand_dst_en[s] = de;
        cand_dst[s]    = 4'(dst);
        cand_src[s][0] = 4'(a);
        cand_src[s][1] = 4'(b);
    endtask

    task automatic rand_cycle();
        logic [7:0] can;
        cand_vld = ($urandom % 5 != 0) ? 2'b11 : 2'($urandom);
        for (int s = 0; s < 2; s++) begin
            cand_unit[s]   = 4'(1 << ($urandom % 4));
            cand_dst_en[s] = 1'($urandom);
            cand_dst[s]    = 4'($urandom);
            cand_src[s][0] = 4'($urandom);
            cand_src[s][1] = 4'($urandom);
        end
        for (int u = 0; u < 4; u++) rs_free[u] = ($urandom % 4 != 0);
        cq_free = 2'($urandom);
        bc_vld  = 1'b0;
        bc_tag  = '0;
        if (m_pend != 0 && $urandom % 3 != 0) begin
            int st = $urandom % 8;
            for (int i = 0; i < 8; i++) begin
                if (!bc_vld && m_pend[(st + i) % 8]) begin
                    bc_vld = 1'b1;
                    bc_tag = 3'((st + i) % 8);
                end
            end
        end
        ret_vld = 2'b00;
        ret_tag = '0;
        can = ~m_free & ~m_pend;
        for (int p = 0; p < 2; p++) begin
            if (can != 0 && $urandom % 3 != 0) begin
                int st = $urandom % 8;
                for (int i = 0; i < 8; i++) begin
                    if (!ret_vld[p] && can[(st + i) % 8]) begin
                        ret_vld[p] = 1'b1;
                        ret_tag[p] = 3'((st + i) % 8);
                        can[(st + i) % 8] = 1'b0;
                    end
                end
            end
        end
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL R1 watchdog: actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd4711);
        idle();
        rst_n = 1'b0;
        m_free = 8'hFF; m_pend = '0; m_mapv = '0; m_mapt = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: idle after reset
        step();
        check("R1", "idle disp_vld", int'(disp_vld), 0);
        adv();

        // R1 / R4: first allocations
        idle();
        set_c(0, 1, 1, 2, 8, 9);
        set_c(1, 2, 1, 5, 10, 11);
        step();
        check("R1", "both dispatch", int'(disp_vld), 3);
        check("R1", "first tag", int'(disp_dst_tag[0]), 0);
        check("R1", "second tag", int'(disp_dst_tag[1]), 1);
        adv();

        // R5 / R6 / R9
        idle();
        set_c(0, 1, 1, 3, 2, 7);
        set_c(1, 2, 0, 0, 3, 5);
        step();
        check("R5", "pending src tag", int'(disp_src_tag[0][0]), 0);
        check("R5", "pending src flag", int'(disp_src_pend[0][0]), 1);
        check("R9", "unmapped not pending", int'(disp_src_pend[0][1]), 0);
        check("R4", "third tag", int'(disp_dst_tag[0]), 2);
        check("R6", "intra-pair pend", int'(disp_src_pend[1][0]), 1);
        check("R6", "intra-pair tag", int'(disp_src_tag[1][0]), 2);
        check("R5", "older mapping tag", int'(disp_src_tag[1][1]), 1);
        adv();

        // R7: same-cycle broadcast
        idle();
        set_c(0, 1, 0, 0, 2, 5);
        bc_vld = 1'b1; bc_tag = 3'd0;
        step();
        check("R7", "same-cycle bc ready", int'(disp_src_pend[0][0]), 0);
        check("R7", "other still pending", int'(disp_src_tag[0][1]), 1);
        adv();
        idle();
        set_c(0, 1, 0, 0, 2, 5);
        step();
        check("R7", "bc sticks", int'(disp_src_pend[0][0]), 0);
        adv();

        // R3: same unit, completion limit; R2: no slot, no station
        idle();
        set_c(0, 4, 0, 0, 0, 0);
        set_c(1, 4, 0, 0, 0, 0);
        step();
        check("R3", "same unit", int'(disp_vld), 1);
        adv();
        idle();
        set_c(0, 1, 0, 0, 0, 0);
        set_c(1, 2, 0, 0, 0, 0);
        cq_free = 2'd1;
        step();
        check("R3", "cq one", int'(disp_vld), 1);
        adv();
        cq_free = 2'd0;
        step();
        check("R2", "cq zero", int'(disp_vld), 0);
        adv();
        cq_free = 2'd3;
        rs_free = 4'b1110;
        step();
        check("R2", "older rs busy", int'(disp_vld), 0);
        adv();

        // R8: retire tag 0 and reuse
        idle();
        ret_vld = 2'b01; ret_tag[0] = 3'd0;
        step();
        adv();
        idle();
        set_c(0, 1, 1, 9, 2, 0);
        step();
        check("R8", "retired reg ready", int'(disp_src_pend[0][0]), 0);
        check("R8", "reuse tag", int'(disp_dst_tag[0]), 0);
        adv();

        // R2 / R3: rename exhaustion (free 3..7)
        for (int n = 0; n < 2; n++) begin
            idle();
            set_c(0, 1, 1, 12, 0, 0);
            set_c(1, 2, 1, 13, 0, 0);
            step();
            adv();
        end
        idle();
        set_c(0, 1, 1, 14, 0, 0);
        set_c(1, 2, 1, 15, 0, 0);
        step();
        check("R3", "one buffer left", int'(disp_vld), 1);
        check("R4", "last tag", int'(disp_dst_tag[0]), 7);
        adv();
        idle();
        set_c(0, 1, 1, 14, 0, 0);
        step();
        check("R2", "no buffer", int'(disp_vld), 0);
        adv();
        idle();
        set_c(0, 1, 0, 0, 0, 0);
        step();
        check("R2", "no dest needs none", int'(disp_vld), 1);
        adv();

        // random traffic
        for (int c = 0; c < 4000; c++) begin
            rand_cycle();
            step();
            adv();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule